// File: doc/BRIEF.md
# Four-Channel Serial Controller Register Block

This block is the register front end of a four-channel serial DMA controller. Software programs, for each channel, the start and end addresses of a transmit ring and a receive ring. Each channel sits in its own 256-byte window. Writing a ring start address also sends a one-cycle reload pulse. The DMA engine of that channel uses this pulse to reset its current descriptor pointer to the new start. A shared direction-enable mask gives each channel a transmit enable and a receive enable.

The DMA engines report finished work with single-cycle receive-done and transmit-done pulses. The block keeps a pending flag for each pulse. It shows the pending flags in an interrupt status register and raises an interrupt line while any visible status bit is set. A command register turns channels on and off. How its opcode is decoded depends on a static firmware-mode input, because the two supported firmware builds use different disable codes. A few fixed-value registers give the read-back values the driver expects.

Top module: `sercfg_regs`

## Requirements
- R1: After reset, all ring registers, the direction mask, the channel enables and all pending event flags are zero, and `irq` is low.
- R2: Channel c (0..3) has a register window at byte address 0x100*(c+1). Inside that window, offset 0x80 holds the TX ring start, 0x84 the TX ring end, 0x88 the RX ring start and 0x8C the RX ring end. Each register reads back the last value written and drives the matching ring output.
- R3: A write to a channel's TX start register makes `tx_ring_reload[c]` high for exactly the one cycle after the write. A write to a channel's RX start register does the same for `rx_ring_reload[c]`. No other access pulses either output.
- R4: The direction mask sits at address 0x14 and has two bits per channel at bit 2c. The lower bit of each pair enables TX and the upper bit enables RX. It reads back zero-extended and drives `dir_en`.
- R5: Reading address 0x0 returns the interrupt status. Bit c shows a pending TX event of channel c and bit 4+c shows a pending RX event. Both are visible only while mask bit 2c (the TX enable) is set. `irq` is the OR of all status bits.
- R6: Any write to address 0x0 clears every pending event flag. An event pulse arriving in the same cycle as such a write still leaves its flag set.
- R7: A write to the command register at 0x2C24 carries an opcode in bits [19:12] and a channel number in bits [1:0]. In firmware mode 0, opcode 0x00 enables the channel and opcode 0x10 disables it. Enable state is visible on `ch_enabled`.
- R8: In firmware mode 1, opcode 0x00 enables the channel and opcode 0x30 or 0x50 disables it. In either mode, any opcode not listed for that mode leaves every channel's enable state unchanged.
- R9: Address 0x2C2C reads 0x0000FFFF. Window offset 0x64 reads 0x0000007B. Window offset 0x60 reads 0xFFFFFFFF when `ch_attached[c]` is high and zero otherwise.
- R10: Any other address reads zero, and a write to it changes no register, flag or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 1 | Static firmware mode for command decoding (0 or 1) |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 14 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ch_attached | input | 4 | Line-attached indication per channel |
| tx_done | input | 4 | Single-cycle TX completion pulse per channel |
| rx_done | input | 4 | Single-cycle RX completion pulse per channel |
| ch_enabled | output | 4 | Channel enable state set by commands |
| dir_en | output | 8 | Direction-enable mask, two bits per channel |
| tx_ring_base | output | 128 | TX ring start per channel, channel c at bits [32c+31:32c] |
| tx_ring_limit | output | 128 | TX ring end per channel |
| rx_ring_base | output | 128 | RX ring start per channel |
| rx_ring_limit | output | 128 | RX ring end per channel |
| tx_ring_reload | output | 4 | One-cycle pulse: reload TX current pointer |
| rx_ring_reload | output | 4 | One-cycle pulse: reload RX current pointer |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: four channels, 32-bit data and pointers, and a 14-bit address. With these values the whole register map is reachable, and the status layout puts the RX bits at 4+c exactly as the requirements state. Random traffic runs in both firmware modes. It mixes writes to any address with done pulses, some of which land in the same cycle as a status clear. This covers the mode-specific disable codes, status bits hidden by a cleared TX enable while the RX enable is set, and writes to unmapped space.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  // Global register byte addresses
  localparam int unsigned A_STATUS = 32'h0000;
  localparam int unsigned A_DIRMSK = 32'h0014;
  localparam int unsigned A_CMD    = 32'h2C24;
  localparam int unsigned A_RSP    = 32'h2C2C;

  // Offsets inside a channel window
  localparam logic [7:0] O_LINE    = 8'h60;
  localparam logic [7:0] O_PORT    = 8'h64;
  localparam logic [7:0] O_TXBASE  = 8'h80;
  localparam logic [7:0] O_TXLIMIT = 8'h84;
  localparam logic [7:0] O_RXBASE  = 8'h88;
  localparam logic [7:0] O_RXLIMIT = 8'h8C;

  localparam int unsigned WIN_LG = 8;

  localparam logic [31:0] RSP_OK    = 32'h0000_FFFF;
  localparam logic [31:0] PORT_STAT = 32'h0000_007B;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_ON   = 2'd1,
    ACT_OFF  = 2'd2
  } cmd_act_e;

  function automatic cmd_act_e decode_cmd(input logic mode, input logic [7:0] op);
    cmd_act_e act;
    act = ACT_NONE;
    if (op == 8'h00) begin
      act = ACT_ON;
    end else if (!mode && op == 8'h10) begin
      act = ACT_OFF;
    end else if (mode && (op == 8'h30 || op == 8'h50)) begin
      act = ACT_OFF;
    end
    return act;
  endfunction

endpackage

// File: rtl/sercfg_chan_regs.sv
module sercfg_chan_regs
  import sercfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PTR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [7:0]        off_i,
  input  logic [PTR_W-1:0]  wdata_i,
  input  logic              attached_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PTR_W-1:0]  tx_base_o,
  output logic [PTR_W-1:0]  tx_limit_o,
  output logic [PTR_W-1:0]  rx_base_o,
  output logic [PTR_W-1:0]  rx_limit_o,
  output logic              tx_reload_o,
  output logic              rx_reload_o
);

  logic [PTR_W-1:0] txb_q, txb_d, txl_q, txl_d, rxb_q, rxb_d, rxl_q, rxl_d;
  logic             txr_q, txr_d, rxr_q, rxr_d;
  logic             wen;

  assign wen = sel_i && wr_i;

  // Next-state logic
  always_comb begin
    txb_d = txb_q;
    txl_d = txl_q;
    rxb_d = rxb_q;
    rxl_d = rxl_q;
    txr_d = 1'b0;
    rxr_d = 1'b0;
    if (wen) begin
      case (off_i)
        O_TXBASE:  begin txb_d = wdata_i; txr_d = 1'b1; end
        O_TXLIMIT: txl_d = wdata_i;
        O_RXBASE:  begin rxb_d = wdata_i; rxr_d = 1'b1; end
        O_RXLIMIT: rxl_d = wdata_i;
        default:   ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_q <= '0;
      txl_q <= '0;
      rxb_q <= '0;
      rxl_q <= '0;
      txr_q <= 1'b0;
      rxr_q <= 1'b0;
    end else begin
      txb_q <= txb_d;
      txl_q <= txl_d;
      rxb_q <= rxb_d;
      rxl_q <= rxl_d;
      txr_q <= txr_d;
      rxr_q <= rxr_d;
    end
  end

  // Read data, zero when the window is not addressed
  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (off_i)
        O_LINE:    rdata_o = attached_i ? '1 : '0;
        O_PORT:    rdata_o = DATA_W'(PORT_STAT);
        O_TXBASE:  rdata_o = DATA_W'(txb_q);
        O_TXLIMIT: rdata_o = DATA_W'(txl_q);
        O_RXBASE:  rdata_o = DATA_W'(rxb_q);
        O_RXLIMIT: rdata_o = DATA_W'(rxl_q);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign tx_base_o   = txb_q;
  assign tx_limit_o  = txl_q;
  assign rx_base_o   = rxb_q;
  assign rx_limit_o  = rxl_q;
  assign tx_reload_o = txr_q;
  assign rx_reload_o = rxr_q;

  // R3: a reload pulse carries the start value written in the cycle before
  p_tx_reload_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reload_o |-> (tx_base_o == $past(wdata_i)));
  p_rx_reload_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reload_o |-> (rx_base_o == $past(wdata_i)));
  // R2: ring registers hold when the window is not written
  p_ring_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> ($stable(tx_base_o) && $stable(tx_limit_o) &&
              $stable(rx_base_o) && $stable(rx_limit_o) &&
              !tx_reload_o && !rx_reload_o));

endmodule

// File: rtl/sercfg_cmd_ctl.sv
module sercfg_cmd_ctl
  import sercfg_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              cmd_wr_i,
  input  logic [7:0]        op_i,
  input  logic [CH_W-1:0]   ch_i,
  output logic [NUM_CH-1:0] ch_en_o
);

  logic [NUM_CH-1:0] en_q, en_d, sel_oh;
  cmd_act_e          act;

  assign act = decode_cmd(mode_i, op_i);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      sel_oh[i] = (ch_i == CH_W'(i));
    end
  end

  // Next-state logic
  always_comb begin
    en_d = en_q;
    if (cmd_wr_i) begin
      case (act)
        ACT_ON:  en_d = en_q | sel_oh;
        ACT_OFF: en_d = en_q & ~sel_oh;
        default: ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

  assign ch_en_o = en_q;

  // R7: opcode 0x00 enables the addressed channel in both modes
  p_cmd_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && op_i == 8'h00) |=> ((ch_en_o & $past(sel_oh)) == $past(sel_oh)));
  // R8: mode-specific disable codes clear the addressed channel
  p_cmd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && (mode_i ? (op_i == 8'h30 || op_i == 8'h50) : (op_i == 8'h10)))
      |=> ((ch_en_o & $past(sel_oh)) == '0));
  // R8: unknown opcodes and idle cycles leave the enables untouched
  p_cmd_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr_i || (op_i != 8'h00 && op_i != 8'h10 && op_i != 8'h30 && op_i != 8'h50))
      |=> $stable(ch_en_o));

endmodule

// File: rtl/sercfg_evt_irq.sv
module sercfg_evt_irq #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     tx_evt_i,
  input  logic [NUM_CH-1:0]     rx_evt_i,
  input  logic                  clr_i,
  input  logic [NUM_CH-1:0]     tx_en_i,
  output logic [2*NUM_CH-1:0]   status_o,
  output logic                  irq_o
);

  logic [NUM_CH-1:0] txp_q, txp_d, rxp_q, rxp_d;

  // Next-state logic: clear first, then events win
  always_comb begin
    txp_d = clr_i ? '0 : txp_q;
    rxp_d = clr_i ? '0 : rxp_q;
    txp_d = txp_d | tx_evt_i;
    rxp_d = rxp_d | rx_evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txp_q <= '0;
      rxp_q <= '0;
    end else begin
      txp_q <= txp_d;
      rxp_q <= rxp_d;
    end
  end

  // Both RX and TX visibility follow the TX-enable bit of the channel
  assign status_o = {rxp_q & tx_en_i, txp_q & tx_en_i};
  assign irq_o    = |status_o;

  // R6: a clear with no concurrent event empties all flags
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && tx_evt_i == '0 && rx_evt_i == '0) |=> (txp_q == '0 && rxp_q == '0));
  // R6: an event pulse always leaves its flag set, even against a clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt_i != '0 || rx_evt_i != '0) |=>
      (((txp_q & $past(tx_evt_i)) == $past(tx_evt_i)) &&
       ((rxp_q & $past(rx_evt_i)) == $past(rx_evt_i))));
  // R5: interrupt only with a pending flag on a TX-enabled channel
  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (((txp_q | rxp_q) & tx_en_i) != '0));

endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PTR_W  = 32,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned WIN_W = ADDR_W - WIN_LG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_sel,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic [NUM_CH-1:0]       ch_attached,
  input  logic [NUM_CH-1:0]       tx_done,
  input  logic [NUM_CH-1:0]       rx_done,
  output logic [NUM_CH-1:0]       ch_enabled,
  output logic [2*NUM_CH-1:0]     dir_en,
  output logic [NUM_CH*PTR_W-1:0] tx_ring_base,
  output logic [NUM_CH*PTR_W-1:0] tx_ring_limit,
  output logic [NUM_CH*PTR_W-1:0] rx_ring_base,
  output logic [NUM_CH*PTR_W-1:0] rx_ring_limit,
  output logic [NUM_CH-1:0]       tx_ring_reload,
  output logic [NUM_CH-1:0]       rx_ring_reload,
  output logic                    irq
);

  // Reset: asserted asynchronously, released through two flops
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // Address decode
  logic hit_status, hit_mask, hit_cmd, hit_rsp;
  logic [NUM_CH-1:0] win_sel;
  assign hit_status = (reg_addr == ADDR_W'(A_STATUS));
  assign hit_mask   = (reg_addr == ADDR_W'(A_DIRMSK));
  assign hit_cmd    = (reg_addr == ADDR_W'(A_CMD));
  assign hit_rsp    = (reg_addr == ADDR_W'(A_RSP));

  // Direction-enable mask
  logic [2*NUM_CH-1:0] mask_q, mask_d;
  logic [NUM_CH-1:0]   tx_en;

  always_comb begin
    mask_d = mask_q;
    if (reg_wr && hit_mask) begin
      mask_d = reg_wdata[2*NUM_CH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  assign dir_en = mask_q;

  // Channel windows
  logic [DATA_W-1:0] win_rdata [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign win_sel[c] = (reg_addr[ADDR_W-1:WIN_LG] == WIN_W'(c + 1));
    assign tx_en[c]   = mask_q[2*c];

    sercfg_chan_regs #(
      .DATA_W (DATA_W),
      .PTR_W  (PTR_W)
    ) u_chan (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .sel_i       (win_sel[c]),
      .wr_i        (reg_wr),
      .off_i       (reg_addr[WIN_LG-1:0]),
      .wdata_i     (reg_wdata[PTR_W-1:0]),
      .attached_i  (ch_attached[c]),
      .rdata_o     (win_rdata[c]),
      .tx_base_o   (tx_ring_base[c*PTR_W +: PTR_W]),
      .tx_limit_o  (tx_ring_limit[c*PTR_W +: PTR_W]),
      .rx_base_o   (rx_ring_base[c*PTR_W +: PTR_W]),
      .rx_limit_o  (rx_ring_limit[c*PTR_W +: PTR_W]),
      .tx_reload_o (tx_ring_reload[c]),
      .rx_reload_o (rx_ring_reload[c])
    );
  end

  // Command decoding
  sercfg_cmd_ctl #(
    .NUM_CH (NUM_CH)
  ) u_cmd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mode_i   (mode_sel),
    .cmd_wr_i (reg_wr && hit_cmd),
    .op_i     (reg_wdata[19:12]),
    .ch_i     (reg_wdata[CH_W-1:0]),
    .ch_en_o  (ch_enabled)
  );

  // Event flags and interrupt
  logic [2*NUM_CH-1:0] status;

  sercfg_evt_irq #(
    .NUM_CH (NUM_CH)
  ) u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tx_evt_i (tx_done),
    .rx_evt_i (rx_done),
    .clr_i    (reg_wr && hit_status),
    .tx_en_i  (tx_en),
    .status_o (status),
    .irq_o    (irq)
  );

  // Read multiplexer
  always_comb begin
    reg_rdata = '0;
    if (hit_status) begin
      reg_rdata = DATA_W'(status);
    end else if (hit_mask) begin
      reg_rdata = DATA_W'(mask_q);
    end else if (hit_rsp) begin
      reg_rdata = DATA_W'(RSP_OK);
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        reg_rdata = reg_rdata | win_rdata[c];
      end
    end
  end

  // R4: the mask changes only through a write to its address
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(reg_wr && hit_mask) |=> $stable(dir_en));
  // R9: the command response register reads the success code
  p_rsp_const_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_rsp |-> (reg_rdata == DATA_W'(32'h0000_FFFF)));
  // R10: at most one channel window is decoded at a time
  p_win_onehot_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(win_sel));

endmodule

// File: tb/tb_sercfg_regs.sv
module tb_sercfg_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 14;
  localparam int DW  = 32;
  localparam int PW  = 32;

  logic            clk, rst_n, mode_sel, reg_wr;
  logic [AW-1:0]   reg_addr;
  logic [DW-1:0]   reg_wdata, reg_rdata;
  logic [NCH-1:0]  ch_attached, tx_done, rx_done, ch_enabled;
  logic [2*NCH-1:0] dir_en;
  logic [NCH*PW-1:0] tx_ring_base, tx_ring_limit, rx_ring_base, rx_ring_limit;
  logic [NCH-1:0]  tx_ring_reload, rx_ring_reload;
  logic            irq;

  sercfg_regs dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_attached(ch_attached), .tx_done(tx_done), .rx_done(rx_done),
    .ch_enabled(ch_enabled), .dir_en(dir_en),
    .tx_ring_base(tx_ring_base), .tx_ring_limit(tx_ring_limit),
    .rx_ring_base(rx_ring_base), .rx_ring_limit(rx_ring_limit),
    .tx_ring_reload(tx_ring_reload), .rx_ring_reload(rx_ring_reload),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  logic [31:0] m_txb [NCH];
  logic [31:0] m_txl [NCH];
  logic [31:0] m_rxb [NCH];
  logic [31:0] m_rxl [NCH];
  logic [7:0]  m_mask;
  logic [3:0]  m_txp, m_rxp, m_en;
  logic        m_mode;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  function automatic void model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_txb[c] = '0; m_txl[c] = '0; m_rxb[c] = '0; m_rxl[c] = '0;
    end
    m_mask = '0; m_txp = '0; m_rxp = '0; m_en = '0;
  endfunction

  function automatic void model_write(input logic [13:0] a, input logic [31:0] d);
    int w;
    w = int'(a[13:8]);
    if (a == 14'h0000) begin
      m_txp = '0; m_rxp = '0;
    end else if (a == 14'h0014) begin
      m_mask = d[7:0];
    end else if (a == 14'h2C24) begin
      if (d[19:12] == 8'h00) m_en[d[1:0]] = 1'b1;
      else if (!m_mode && d[19:12] == 8'h10) m_en[d[1:0]] = 1'b0;
      else if (m_mode && (d[19:12] == 8'h30 || d[19:12] == 8'h50)) m_en[d[1:0]] = 1'b0;
    end else if (w >= 1 && w <= NCH) begin
      case (a[7:0])
        8'h80: m_txb[w-1] = d;
        8'h84: m_txl[w-1] = d;
        8'h88: m_rxb[w-1] = d;
        8'h8C: m_rxl[w-1] = d;
        default: ;
      endcase
    end
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = '0;
    for (int c = 0; c < NCH; c++) begin
      if (m_mask[2*c]) begin
        s[c]   = m_txp[c];
        s[4+c] = m_rxp[c];
      end
    end
    return s;
  endfunction

  function automatic logic [31:0] exp_read(input logic [13:0] a);
    int w;
    w = int'(a[13:8]);
    if (a == 14'h0000) return exp_status();
    if (a == 14'h0014) return {24'h0, m_mask};
    if (a == 14'h2C2C) return 32'h0000FFFF;
    if (w >= 1 && w <= NCH) begin
      case (a[7:0])
        8'h60: return ch_attached[w-1] ? 32'hFFFFFFFF : 32'h0;
        8'h64: return 32'h0000007B;
        8'h80: return m_txb[w-1];
        8'h84: return m_txl[w-1];
        8'h88: return m_rxb[w-1];
        8'h8C: return m_rxl[w-1];
        default: return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle with optional write and event pulses
  task automatic drive(input bit w, input logic [13:0] a, input logic [31:0] d,
                       input logic [3:0] txe, input logic [3:0] rxe);
    logic [3:0] etr, err;
    int win;
    etr = '0; err = '0;
    win = int'(a[13:8]);
    if (w && win >= 1 && win <= NCH) begin
      if (a[7:0] == 8'h80) etr[win-1] = 1'b1;
      if (a[7:0] == 8'h88) err[win-1] = 1'b1;
    end
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; tx_done = txe; rx_done = rxe;
    @(negedge clk);
    if (w) model_write(a, d);
    m_txp = m_txp | txe;
    m_rxp = m_rxp | rxe;
    chk("R3 tx reload", {28'h0, tx_ring_reload}, {28'h0, etr});
    chk("R3 rx reload", {28'h0, rx_ring_reload}, {28'h0, err});
    reg_wr = 1'b0; tx_done = '0; rx_done = '0;
  endtask

  task automatic rd(input logic [13:0] a, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp_read(a));
  endtask

  task automatic chk_outs(input string tag);
    #1;
    chk({tag, " R7 ch_enabled"}, {28'h0, ch_enabled}, {28'h0, m_en});
    chk("R4 dir_en", {24'h0, dir_en}, {24'h0, m_mask});
    chk("R5 irq", {31'h0, irq}, {31'h0, (exp_status() != 0)});
    for (int c = 0; c < NCH; c++) begin
      chk("R2 tx base out", tx_ring_base[c*PW +: PW], m_txb[c]);
      chk("R2 tx limit out", tx_ring_limit[c*PW +: PW], m_txl[c]);
      chk("R2 rx base out", rx_ring_base[c*PW +: PW], m_rxb[c]);
      chk("R2 rx limit out", rx_ring_limit[c*PW +: PW], m_rxl[c]);
    end
  endtask

  function automatic logic [13:0] rand_addr();
    logic [7:0] offs [6];
    int s;
    offs[0] = 8'h60; offs[1] = 8'h64; offs[2] = 8'h80;
    offs[3] = 8'h84; offs[4] = 8'h88; offs[5] = 8'h8C;
    s = int'($urandom % 10);
    case (s)
      0: return 14'h0000;
      1: return 14'h0014;
      2: return 14'h2C24;
      3: return 14'h2C2C;
      8: return 14'($urandom) & 14'h3FFC;
      9: return {6'(5 + $urandom % 59), 8'($urandom) & 8'hFC};
      default: return {6'(1 + $urandom % 4), offs[$urandom % 6]};
    endcase
  endfunction

  function automatic logic [31:0] rand_data(input logic [13:0] a);
    logic [7:0] ops [5];
    ops[0] = 8'h00; ops[1] = 8'h10; ops[2] = 8'h30; ops[3] = 8'h50; ops[4] = 8'($urandom);
    if (a == 14'h2C24) return {12'h0, ops[$urandom % 5], 10'h0, 2'($urandom)};
    return $urandom;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_done = '0; rx_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  function automatic logic [13:0] wa(input int c, input logic [7:0] off);
    return {6'(c + 1), off};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=60000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    ch_attached = 4'b0101;
    mode_sel = 1'b0; m_mode = 1'b0;
    do_reset();

    // R1: reset state
    rd(14'h0000, "R1 status after reset");
    rd(14'h0014, "R1 mask after reset");
    for (int c = 0; c < NCH; c++) rd(wa(c, 8'h80), "R1 ring reg after reset");
    chk_outs("R1");

    // R2/R3: program every ring register
    for (int c = 0; c < NCH; c++) begin
      drive(1, wa(c, 8'h80), 32'h1000_0000 + c*32'h100, 0, 0);
      drive(1, wa(c, 8'h84), 32'h1000_0080 + c*32'h100, 0, 0);
      drive(1, wa(c, 8'h88), 32'h2000_0000 + c*32'h100, 0, 0);
      drive(1, wa(c, 8'h8C), 32'h2000_00F8 + c*32'h100, 0, 0);
    end
    for (int c = 0; c < NCH; c++) begin
      rd(wa(c, 8'h80), "R2 tx start"); rd(wa(c, 8'h84), "R2 tx end");
      rd(wa(c, 8'h88), "R2 rx start"); rd(wa(c, 8'h8C), "R2 rx end");
    end
    chk_outs("R2");

    // R4: mask write and zero-extended read-back
    drive(1, 14'h0014, 32'hFFFF_FF3C, 0, 0);
    rd(14'h0014, "R4 mask readback");
    chk_outs("R4");

    // R5: RX visibility follows TX enable, not RX enable
    drive(1, 14'h0014, 32'h0000_0000, 0, 0);
    drive(0, 14'h0000, 0, 4'b0001, 4'b0010);
    rd(14'h0000, "R5 status hidden by mask");
    chk_outs("R5 hidden");
    drive(1, 14'h0014, 32'h0000_0008, 0, 0);
    rd(14'h0000, "R5 rx-enable alone hides");
    drive(1, 14'h0014, 32'h0000_0015, 0, 0);
    chk(" R5 status bits 0 and 5", exp_status(), 32'h21);
    rd(14'h0000, "R5 status visible");
    chk_outs("R5 visible");

    // R6: clear, and event winning over a simultaneous clear
    drive(1, 14'h0000, 32'h0, 0, 0);
    rd(14'h0000, "R6 cleared");
    drive(0, 14'h0000, 0, 4'b0001, 4'b0001);
    drive(1, 14'h0000, 32'hDEAD_BEEF, 4'b0100, 4'b0000);
    chk("R6 model set-wins", exp_status(), 32'h4);
    rd(14'h0000, "R6 set wins over clear");
    chk_outs("R6");

    // R7: mode 0 commands
    drive(1, 14'h2C24, 32'h0000_0003, 0, 0);
    chk_outs("R7 enable ch3");
    drive(1, 14'h2C24, 32'h0003_0003, 0, 0);
    chk_outs("R8 mode0 ignores 0x30");
    drive(1, 14'h2C24, 32'h0001_0003, 0, 0);
    chk_outs("R7 disable ch3");

    // R8: mode 1 commands
    mode_sel = 1'b1; m_mode = 1'b1;
    drive(1, 14'h2C24, 32'h0000_0000, 0, 0);
    drive(1, 14'h2C24, 32'h0000_0001, 0, 0);
    drive(1, 14'h2C24, 32'h0001_0000, 0, 0);
    chk_outs("R8 mode1 ignores 0x10");
    drive(1, 14'h2C24, 32'h0003_0000, 0, 0);
    drive(1, 14'h2C24, 32'h0005_0001, 0, 0);
    chk_outs("R8 mode1 0x30/0x50 disable");
    drive(1, 14'h2C24, 32'h000A_0002, 0, 0);
    chk_outs("R8 unknown opcode");

    // R9: constant registers
    rd(14'h2C2C, "R9 response");
    for (int c = 0; c < NCH; c++) begin
      rd(wa(c, 8'h64), "R9 port status");
      rd(wa(c, 8'h60), "R9 line signals");
    end

    // R10: unmapped space
    rd(14'h2C28, "R10 unmapped read");
    rd(14'h0500, "R10 beyond windows");
    drive(1, 14'h2C30, 32'hFFFF_FFFF, 0, 0);
    drive(1, wa(1, 8'h90), 32'hFFFF_FFFF, 0, 0);
    drive(1, 14'h0010, 32'hFFFF_FFFF, 0, 0);
    rd(14'h0000, "R10 status untouched");
    rd(14'h0014, "R10 mask untouched");
    chk_outs("R10");

    // Random phase in both modes
    for (int ph = 0; ph < 2; ph++) begin
      @(negedge clk);
      mode_sel = ph[0]; m_mode = ph[0];
      for (int k = 0; k < 300; k++) begin
        logic [13:0] a;
        int act;
        a = rand_addr();
        act = int'($urandom % 8);
        if (act <= 3) begin
          drive(1, a, rand_data(a), 4'($urandom & ($urandom)), 4'($urandom & ($urandom)));
        end else if (act <= 6) begin
          rd(a, "R10 random read");
        end else begin
          drive(0, a, 0, 4'($urandom), 4'($urandom));
        end
        if (k % 10 == 0) chk_outs("R8 random");
      end
      rd(14'h0000, "R5 random status");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule